// File: doc/BRIEF.md
# Two-wire bus START/STOP condition detector

This block watches the clock line (SCL) and data line (SDA) of a two-wire serial bus and reports bus conditions. A START is an SDA falling edge while SCL is high. A STOP is an SDA rising edge while SCL is high. A condition is accepted only when its timing qualifies: SCL must have been high for a setup window before the SDA edge, and both lines must hold still for a hold window after it. An accepted condition sets (START) or clears (STOP) a bus-busy flag after a settle delay. A one-cycle pulse on `start_pulse` or `stop_pulse` marks that same cycle.

All windows are counted in half-cycles of the bus system clock. A clock-enable tick fires once per `HALF_DIV` fabric clocks and supplies these half-cycles. In standard mode the windows come from a 5-bit control value. A zero control value is read as 2, and an odd value is rounded up to the next even value. In high-speed mode the windows are short and fixed. Both pins pass through a `SYNC_STAGES`-deep synchronizer before edge detection.

The engine is a three-state machine:
- `ST_IDLE` waits for a qualified SDA edge. Transition I→H needs SCL high and the setup window met.
- `ST_HOLD` counts the hold window. Transition H→I (abort) happens if SCL falls or SDA moves. Transition H→I (release fail) happens at the end of the hold window if the total SCL-high time is short. Transition H→S happens when the window ends cleanly.
- `ST_SETTLE` counts up to the flag-update point. Transition S→I (fire) updates the flag and issues the pulse.

Edges that arrive during `ST_SETTLE` are ignored.

Top module: `busline_cond_detect`

## Requirements
- R1: After reset, `bus_busy`, `start_pulse` and `stop_pulse` are all 0.
- R2: A qualified SDA falling edge with SCL high produces one `start_pulse` and leaves `bus_busy` at 1.
- R3: A qualified SDA rising edge with SCL high produces one `stop_pulse` and leaves `bus_busy` at 0.
- R4: Let E be the normalised control value. In standard mode, an SDA edge is ignored (no pulse, flag unchanged) unless SCL has been high for at least E+2 half-cycles before it. SCL must also stay high for 2E+2 half-cycles in total up to the end of the hold window.
- R5: An edge is ignored if SDA changes again, or SCL falls, within the hold window that follows it. In standard mode the hold window is E half-cycles.
- R6: In standard mode, the flag update comes E+3 half-cycles after the edge is captured. With one clock per half-cycle and two synchronizer stages, the pulse is driven at the (E+6)-th rising clock edge after the SDA pin change.
- R7: In high-speed mode (`fast_mode`=1), the windows are setup 4, hold 4, release 8 and flag delay 7 half-cycles, whatever the control value. With one clock per half-cycle the pulse comes at the 10th rising edge.
- R8: A control value of 0 behaves as 2, and an odd control value v behaves as v+1.
- R9: SDA transitions while SCL is low produce no pulse and leave the flag unchanged.
- R10: Each pulse lasts exactly one clock cycle, and `start_pulse` and `stop_pulse` are never high together.
- R11: A START while busy gives a `start_pulse` and keeps the flag at 1. A STOP while idle gives a `stop_pulse` and keeps the flag at 0.
- R12: A setup time of 6 half-cycles qualifies a START in high-speed mode but not in standard mode with control value 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_pin | input | 1 | Raw SCL line level |
| sda_pin | input | 1 | Raw SDA line level |
| fast_mode | input | 1 | 1 selects the fixed high-speed windows |
| setup_ctl | input | 5 | Even timing control value for standard mode |
| start_pulse | output | 1 | One-cycle pulse when a START is accepted |
| stop_pulse | output | 1 | One-cycle pulse when a STOP is accepted |
| bus_busy | output | 1 | Set by START, cleared by STOP |

## Verification
The bench builds the detector with `HALF_DIV`=1, so every fabric clock is one half-cycle of the bus clock. This makes the flag delay an exact clock-edge count, and the bench checks it for several control values, including a zero and an odd one. The default synchronizer depth of two is kept, which fixes the three-edge capture latency the bench expects. Setup and hold violations are placed well inside the windows, so accept and reject cases do not depend on one-cycle rounding.

// File: rtl/bcdet_pkg.sv
package bcdet_pkg;
    localparam int unsigned CTL_W  = 5;
    localparam int unsigned EVEN_W = CTL_W + 1;
    localparam int unsigned WIN_W  = CTL_W + 3;

    localparam int unsigned FAST_REL   = 8;
    localparam int unsigned FAST_SETUP = 4;
    localparam int unsigned FAST_HOLD  = 4;
    localparam int unsigned FAST_FLAG  = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SETTLE
    } det_state_e;

    // All windows in half-cycles of the bus system clock
    typedef struct packed {
        logic [WIN_W-1:0] rel_w;
        logic [WIN_W-1:0] su_w;
        logic [WIN_W-1:0] hd_w;
        logic [WIN_W-1:0] fl_w;
    } det_win_t;

    // Zero reads as 2, odd rounds up, so no window can reach zero
    function automatic logic [EVEN_W-1:0] even_ctl(input logic [CTL_W-1:0] v);
        logic [EVEN_W-1:0] e;
        e = {1'b0, v};
        if (v == '0) begin
            e = EVEN_W'(2);
        end else if (v[0]) begin
            e = e + EVEN_W'(1);
        end
        return e;
    endfunction
endpackage

// File: rtl/bcdet_sync.sv
module bcdet_sync #(
    parameter int unsigned WIDTH     = 2,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {(STAGES*WIDTH){RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two or more stages");
    end
endmodule

// File: rtl/bcdet_tick.sv
module bcdet_tick #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned DIV_W = $clog2(HALF_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/bcdet_windows.sv
module bcdet_windows
    import bcdet_pkg::*;
(
    input  logic             fast_mode,
    input  logic [CTL_W-1:0] setup_ctl,
    output det_win_t         win
);
    logic [EVEN_W-1:0] ev;
    logic [WIN_W-1:0]  ew;

    always_comb begin
        ev = even_ctl(setup_ctl);
        ew = WIN_W'(ev);
        if (fast_mode) begin
            win.rel_w = WIN_W'(FAST_REL);
            win.su_w  = WIN_W'(FAST_SETUP);
            win.hd_w  = WIN_W'(FAST_HOLD);
            win.fl_w  = WIN_W'(FAST_FLAG);
        end else begin
            win.rel_w = (ew << 1) + WIN_W'(2);
            win.su_w  = ew + WIN_W'(2);
            win.hd_w  = ew;
            win.fl_w  = ew + WIN_W'(3);
        end
    end
endmodule

// File: rtl/bcdet_fsm.sv
module bcdet_fsm
    import bcdet_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     s_scl,
    input  logic     s_sda,
    input  det_win_t win,
    output logic     start_pulse,
    output logic     stop_pulse,
    output logic     bus_busy
);
    det_state_e       state_q, state_d;
    logic             prev_sda_q;
    logic [WIN_W-1:0] scl_hi_q;
    logic [WIN_W-1:0] cnt_q;
    logic             stop_kind_q;

    logic sda_edge, setup_ok, rel_ok, hold_last, settle_last, fire;

    assign sda_edge    = s_sda ^ prev_sda_q;
    assign setup_ok    = (scl_hi_q >= win.su_w);
    assign rel_ok      = (scl_hi_q >= win.rel_w);
    assign hold_last   = tick && (cnt_q == win.hd_w - WIN_W'(1));
    assign settle_last = tick && (cnt_q == win.fl_w - WIN_W'(1));
    assign fire        = (state_q == ST_SETTLE) && settle_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sda_edge && s_scl && setup_ok) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!s_scl || sda_edge) begin
                    state_d = ST_IDLE;
                end else if (hold_last) begin
                    state_d = rel_ok ? ST_SETTLE : ST_IDLE;
                end
            end
            ST_SETTLE: begin
                if (settle_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sda_q  <= 1'b1;
            scl_hi_q    <= '0;
            cnt_q       <= '0;
            stop_kind_q <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            bus_busy    <= 1'b0;
        end else begin
            prev_sda_q <= s_sda;

            if (!s_scl) begin
                scl_hi_q <= '0;
            end else if (tick && (scl_hi_q != '1)) begin
                scl_hi_q <= scl_hi_q + WIN_W'(1);
            end

            if (state_q == ST_IDLE && state_d == ST_HOLD) begin
                cnt_q       <= '0;
                stop_kind_q <= s_sda;
            end else if (tick) begin
                cnt_q <= cnt_q + WIN_W'(1);
            end

            start_pulse <= fire && !stop_kind_q;
            stop_pulse  <= fire && stop_kind_q;
            if (fire) begin
                bus_busy <= !stop_kind_q;
            end
        end
    end

    a_r10_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse));

    a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    a_r10_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> start_pulse);

    a_r3_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> stop_pulse);

    a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> bus_busy);

    a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !bus_busy);

    a_r5_hold_needs_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) && !s_scl |=> (state_q == ST_IDLE));

    a_r4_entry_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) ##1 (state_q == ST_HOLD) |-> $past(scl_hi_q) >= $past(win.su_w));
endmodule

// File: rtl/busline_cond_detect.sv
module busline_cond_detect
    import bcdet_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_pin,
    input  logic             sda_pin,
    input  logic             fast_mode,
    input  logic [CTL_W-1:0] setup_ctl,
    output logic             start_pulse,
    output logic             stop_pulse,
    output logic             bus_busy
);
    logic [1:0] pins_s;
    logic       tick;
    det_win_t   win;

    bcdet_sync #(
        .WIDTH    (2),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_pin, sda_pin}),
        .q    (pins_s)
    );

    bcdet_tick #(
        .HALF_DIV(HALF_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    bcdet_windows u_win (
        .fast_mode(fast_mode),
        .setup_ctl(setup_ctl),
        .win      (win)
    );

    bcdet_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .s_scl      (pins_s[1]),
        .s_sda      (pins_s[0]),
        .win        (win),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .bus_busy   (bus_busy)
    );

    a_r7_window_order: assert property (@(posedge clk) disable iff (!rst_n)
        (win.hd_w < win.fl_w) && (win.su_w <= win.rel_w));
endmodule

// File: tb/busline_cond_detect_tb.sv
module busline_cond_detect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_pin = 1'b0;
    logic       sda_pin = 1'b1;
    logic       fast_mode = 1'b0;
    logic [4:0] setup_ctl = 5'd24;
    logic       start_pulse, stop_pulse, bus_busy;

    int checks = 0;
    int errors = 0;
    logic exp_busy = 1'b0;

    always #2 clk = ~clk;

    busline_cond_detect #(.HALF_DIV(1), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .sda_pin(sda_pin),
        .fast_mode(fast_mode), .setup_ctl(setup_ctl),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_busy(bus_busy)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // is_stop: 0 START, 1 STOP; su_n: SCL-high cycles before the SDA edge
    // brk: cycle at which the hold is disturbed (0 none); brk_scl: drop SCL instead of SDA
    task automatic run_cond(input bit is_stop, input bit fast, input logic [4:0] ctl,
                            input int su_n, input int brk, input bit brk_scl,
                            input bit accept, input int exp_k, input string tag);
        int first_k, want_cnt, other_cnt;
        first_k = 0; want_cnt = 0; other_cnt = 0;
        @(negedge clk);
        fast_mode = fast;
        setup_ctl = ctl;
        scl_pin = 1'b0;
        idle_cycles(2);
        sda_pin = is_stop ? 1'b0 : 1'b1;
        idle_cycles(5);
        scl_pin = 1'b1;
        idle_cycles(su_n);
        sda_pin = is_stop ? 1'b1 : 1'b0;
        for (int k = 1; k <= 80; k++) begin
            @(posedge clk);
            @(negedge clk);
            if ((is_stop ? stop_pulse : start_pulse)) begin
                want_cnt++;
                if (first_k == 0) first_k = k;
            end
            if ((is_stop ? start_pulse : stop_pulse)) other_cnt++;
            if (brk != 0 && k == brk) begin
                if (brk_scl) scl_pin = 1'b0;
                else sda_pin = ~sda_pin;
            end
        end
        if (accept) begin
            exp_busy = !is_stop;
            chk(first_k == exp_k, tag, "pulse edge index", first_k, exp_k);
            chk(want_cnt == 1, "R10", "pulse length in cycles", want_cnt, 1);
        end else begin
            chk(want_cnt == 0, tag, "pulses on rejected condition", want_cnt, 0);
        end
        chk(other_cnt == 0, "R10", "opposite pulses", other_cnt, 0);
        chk(bus_busy == exp_busy, tag, "busy flag", int'(bus_busy), int'(exp_busy));
        scl_pin = 1'b0;
        idle_cycles(4);
    endtask

    task automatic t_reset();
        idle_cycles(3);
        chk(bus_busy == 1'b0, "R1", "busy in reset", int'(bus_busy), 0);
        rst_n = 1'b1;
        idle_cycles(6);
        chk(bus_busy == 1'b0, "R1", "busy after reset", int'(bus_busy), 0);
        chk(start_pulse == 1'b0 && stop_pulse == 1'b0, "R1", "pulses after reset",
            int'(start_pulse) + int'(stop_pulse), 0);
    endtask

    task automatic t_std_start_stop();
        run_cond(1'b0, 1'b0, 5'd24, 40, 0, 1'b0, 1'b1, 30, "R2");
        run_cond(1'b1, 1'b0, 5'd24, 40, 0, 1'b0, 1'b1, 30, "R3");
        run_cond(1'b0, 1'b0, 5'd24, 40, 0, 1'b0, 1'b1, 30, "R6");
        run_cond(1'b1, 1'b0, 5'd24, 40, 0, 1'b0, 1'b1, 30, "R6");
    endtask

    task automatic t_setup_violation();
        run_cond(1'b0, 1'b0, 5'd24, 20, 0, 1'b0, 1'b0, 0, "R4");
        run_cond(1'b0, 1'b0, 5'd24, 6, 0, 1'b0, 1'b0, 0, "R12");
    endtask

    task automatic t_hold_violation();
        run_cond(1'b0, 1'b0, 5'd24, 40, 10, 1'b0, 1'b0, 0, "R5");
        run_cond(1'b0, 1'b0, 5'd24, 40, 10, 1'b1, 1'b0, 0, "R5");
    endtask

    task automatic t_scl_low_toggles();
        int cnt;
        cnt = 0;
        @(negedge clk);
        scl_pin = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 0) sda_pin = ~sda_pin;
            @(negedge clk);
            cnt += int'(start_pulse) + int'(stop_pulse);
        end
        idle_cycles(40);
        chk(cnt == 0, "R9", "pulses with SCL low", cnt, 0);
        chk(bus_busy == exp_busy, "R9", "busy with SCL low", int'(bus_busy), int'(exp_busy));
    endtask

    task automatic t_fast_mode();
        run_cond(1'b0, 1'b1, 5'd24, 6, 0, 1'b0, 1'b1, 10, "R12");
        run_cond(1'b1, 1'b1, 5'd2, 6, 0, 1'b0, 1'b1, 10, "R7");
        run_cond(1'b0, 1'b1, 5'd24, 2, 0, 1'b0, 1'b0, 0, "R7");
    endtask

    task automatic t_normalise_and_repeat();
        run_cond(1'b0, 1'b0, 5'd0, 40, 0, 1'b0, 1'b1, 8, "R8");
        run_cond(1'b0, 1'b0, 5'd2, 40, 0, 1'b0, 1'b1, 8, "R11");
        run_cond(1'b1, 1'b0, 5'd5, 40, 0, 1'b0, 1'b1, 12, "R8");
        run_cond(1'b1, 1'b0, 5'd5, 40, 0, 1'b0, 1'b1, 12, "R11");
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_std_start_stop();
        t_setup_violation();
        t_hold_violation();
        t_scl_low_toggles();
        t_fast_mode();
        t_normalise_and_repeat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule